// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns CPU access requests into external bus cycles on a bus whose low address byte and data byte share one set of lines. Each bus cycle lasts one period of the E clock. An address strobe (AS) pulses while E is low to mark the address phase, and the data phase runs while E is high. The block runs from an internal clock at eight times the E rate. A 3-bit phase counter therefore places every edge on an eighth-of-cycle boundary. Phase 0 begins at the falling edge of E.

The requester presents a request with a direction flag, a 16-bit address and write data. The request is sampled only in phase 0. An accept pulse in phase 1 tells the requester to withdraw it. The block drives the low address byte during the address phase and the write data during the data phase. On a read it releases the shared lines, captures the returned byte at the fall of E, and keeps the lines released for one more eighth of a cycle so the device can let go of them. A done pulse marks the end of every requested cycle. When no request is pending, E and AS keep running, R/W reads high and the shared lines stay released.

Top module: `mab_seq_top`

## Requirements
- R1: While reset is asserted, e_o=0, as_o=0, ad_oe_o=0, rw_o=1, done_o=0 and accept_o=0.
- R2: E has a period of eight internal clocks. It is low in phases 0-3 and high in phases 4-7, and phase 0 is the first clock after E falls.
- R3: AS is high in phases 1 and 2 only, so it rises one clock after E falls and falls one clock before E rises.
- R4: req_i is sampled only in phase 0. A sampled request gives accept_o=1 in phase 1 of the same cycle. A request that is high only in phases 1-7 starts no cycle: no accept, no drive, rw_o stays 1 and no done.
- R5: For an accepted cycle, addr_hi_o carries addr_i[15:8] and rw_o carries the request's direction (1 = read, 0 = write) from phase 1 through phase 0 of the following cycle.
- R6: In phases 1-3 of an accepted cycle, ad_oe_o=1 and ad_o carries addr_i[7:0].
- R7: On a write, ad_oe_o=1 and ad_o carries the write byte in phases 4-7 and in phase 0 of the following cycle.
- R8: On a read, ad_oe_o=0 in phases 4-7 and in phase 0 of the following cycle.
- R9: On a read, ad_i is captured at the fall of E (the end of phase 7). rdata_o shows it from the next phase 0 on. done_o is high for exactly that phase-0 clock after every accepted cycle, read or write.
- R10: In a cycle with no accepted request, ad_oe_o=0 and rw_o=1, done_o stays low in the next phase 0, and rdata_o keeps its value whatever ad_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, eight times the E rate |
| arst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled in phase 0 |
| rw_i | input | 1 | Direction of the request: 1 read, 0 write |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| ad_i | input | 8 | Shared lines as seen from the pads |
| e_o | output | 1 | E clock |
| as_o | output | 1 | Address strobe |
| rw_o | output | 1 | Bus direction, 1 = read |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Byte driven onto the shared lines |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| accept_o | output | 1 | One-clock request-accept pulse |

## Verification
Everything is timed from the falling edge of E, which the bench finds by sampling e_o at the falling clock edges. Each later sample is counted as the next phase. A request driven in phase 0 shows up as accept_o, the address on the shared lines and the new R/W one clock later, in phase 1. Write data is due in phase 4. The captured read byte and the done pulse are due in the phase 0 after that, eight clocks after the request was sampled. The checks sample at those exact phases and also check the neighbouring phases, so an output that arrives one clock early or late is caught.

// File: rtl/mab_pkg.sv
package mab_pkg;
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_START  = 3'd0;
  localparam phase_t PH_AS_ON  = 3'd1;
  localparam phase_t PH_AS_OFF = 3'd3;
  localparam phase_t PH_E_ON   = 3'd4;
  localparam phase_t PH_LAST   = 3'd7;

  typedef struct packed {
    logic act;
    logic rd;
  } cyc_t;
endpackage

// File: rtl/mab_rst_sync.sv
module mab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/mab_phase_gen.sv
module mab_phase_gen
  import mab_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase_o,
  output logic   first_o,
  output logic   last_o,
  output logic   e_o,
  output logic   as_o
);
  phase_t ph_q, ph_d;
  logic   e_q, e_d, as_q, as_d;

  always_comb begin
    ph_d = ph_q + 1'b1;
    e_d  = (ph_d >= PH_E_ON);
    as_d = (ph_d >= PH_AS_ON) && (ph_d < PH_AS_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_START;
      e_q  <= 1'b0;
      as_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      e_q  <= e_d;
      as_q <= as_d;
    end
  end

  assign phase_o = ph_q;
  assign first_o = (ph_q == PH_START);
  assign last_o  = (ph_q == PH_LAST);
  assign e_o     = e_q;
  assign as_o    = as_q;
endmodule

// File: rtl/mab_cycle_ctl.sv
module mab_cycle_ctl
  import mab_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          req_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output cyc_t          cyc_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          accept_o,
  output logic          done_o
);
  cyc_t          cyc_q, cyc_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          acc_q, done_q, acc_d, done_d;
  logic          load, cyc_en;

  always_comb begin
    load   = first_i & req_i;
    cyc_en = first_i;
    cyc_d  = cyc_q;
    if (load) begin
      cyc_d.act = 1'b1;
      cyc_d.rd  = rw_i;
    end else begin
      cyc_d.act = 1'b0;
      cyc_d.rd  = 1'b1;
    end
    acc_d  = load;
    done_d = last_i & cyc_q.act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '{act: 1'b0, rd: 1'b1};
      addr_q <= '0;
      wd_q   <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cyc_en) cyc_q <= cyc_d;
      if (load) begin
        addr_q <= addr_i;
        wd_q   <= wdata_i;
      end
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  assign cyc_o    = cyc_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wd_q;
  assign accept_o = acc_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mab_bus_mux.sv
module mab_bus_mux
  import mab_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase_i,
  input  logic          last_i,
  input  cyc_t          cyc_i,
  input  logic [DW-1:0] addr_lo_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_q;
  logic          cap_en;

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (cyc_i.act) begin
      if ((phase_i >= PH_AS_ON) && (phase_i < PH_E_ON)) begin
        ad_oe_o = 1'b1;
        ad_o    = addr_lo_i;
      end else if (!cyc_i.rd) begin
        // data phase of a write, plus the hold clock after E falls
        ad_oe_o = 1'b1;
        ad_o    = wdata_i;
      end
    end
    cap_en = last_i & cyc_i.act & cyc_i.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= ad_i;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mab_seq_top.sv
module mab_seq_top
  import mab_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          req_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ad_i,
  output logic          e_o,
  output logic          as_o,
  output logic          rw_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          accept_o
);
  logic          rst_n, first, last;
  phase_t        phase;
  cyc_t          cyc;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;

  mab_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  mab_phase_gen u_ph (
    .clk(clk), .rst_n(rst_n), .phase_o(phase), .first_o(first),
    .last_o(last), .e_o(e_o), .as_o(as_o)
  );

  mab_cycle_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .first_i(first), .last_i(last),
    .req_i(req_i), .rw_i(rw_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .cyc_o(cyc), .addr_o(addr_q), .wdata_o(wd_q),
    .accept_o(accept_o), .done_o(done_o)
  );

  mab_bus_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .last_i(last), .cyc_i(cyc),
    .addr_lo_i(addr_q[DW-1:0]), .wdata_i(wd_q), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .rdata_o(rdata_o)
  );

  assign rw_o      = cyc.act ? cyc.rd : 1'b1;
  assign addr_hi_o = addr_q[AW-1:DW];

  // R3: E rises one clock after AS falls
  a_r3_as_then_e: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_o) |=> $rose(e_o));
  // R3: AS stays high for exactly two clocks
  a_r3_as_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_o) |=> as_o ##1 !as_o);
  // R4: accept comes with the rise of AS
  a_r4_accept_at_as: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $rose(as_o));
  // R7: a write drives the lines while E is high
  a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (e_o && !rw_o) |-> ad_oe_o);
  // R8: the lines are never driven while E is high and R/W reads
  a_r8_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (e_o && rw_o) |-> !ad_oe_o);
  // R9: done appears only in the clock after E falls
  a_r9_done_at_efall: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(e_o));
endmodule

// File: tb/tb_mab_seq_top.sv
`timescale 1ns/1ps
module tb_mab_seq_top;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       req_i = 1'b0, rw_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0, ad_i = '0;
  logic       e_o, as_o, rw_o, ad_oe_o, done_o, accept_o;
  logic [7:0] addr_hi_o, ad_o, rdata_o;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mab_seq_top dut (
    .clk(clk), .arst_n(arst_n), .req_i(req_i), .rw_i(rw_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ad_i(ad_i), .e_o(e_o), .as_o(as_o), .rw_o(rw_o),
    .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .rdata_o(rdata_o),
    .done_o(done_o), .accept_o(accept_o)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance to the falling-edge sample at which E has just fallen (phase 0).
  task automatic sync_p0();
    logic pe;
    int n = 0;
    pe = e_o;
    @(negedge clk);
    while (!(pe && !e_o) && n < 20) begin
      pe = e_o; n++;
      @(negedge clk);
    end
    ck("R2 E fall found", (n < 20), 1);
  endtask

  // Starts in phase 0, ends in the following phase 0.
  task automatic run_cycle(input bit rd, input logic [15:0] a, input logic [7:0] d);
    req_i = 1'b1; rw_i = rd; addr_i = a; wdata_i = d;
    for (int p = 1; p < 8; p++) begin
      @(negedge clk);
      ck("R2 e level", e_o, (p >= 4));
      ck("R3 as level", as_o, (p == 1 || p == 2));
      ck("R4 accept", accept_o, (p == 1));
      if (p == 1) begin req_i = 1'b0; addr_i = ~a; wdata_i = ~d; end
      ck("R5 rw", rw_o, rd);
      ck("R5 addr hi", addr_hi_o, a[15:8]);
      if (p < 4) begin
        ck("R6 oe addr", ad_oe_o, 1);
        ck("R6 addr lo", ad_o, a[7:0]);
      end else if (rd) begin
        ck("R8 read release", ad_oe_o, 0);
        if (p == 4) ad_i = d;
      end else begin
        ck("R7 write oe", ad_oe_o, 1);
        ck("R7 write data", ad_o, d);
      end
    end
    @(negedge clk);
    ck("R2 e low at p0", e_o, 0);
    ck("R9 done", done_o, 1);
    ck("R5 rw hold p0", rw_o, rd);
    ck("R5 addr hi hold p0", addr_hi_o, a[15:8]);
    if (rd) begin
      ck("R9 rdata", rdata_o, d);
      ck("R8 turnaround p0", ad_oe_o, 0);
      ad_i = ~d;
    end else begin
      ck("R7 hold oe p0", ad_oe_o, 1);
      ck("R7 hold data p0", ad_o, d);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    ck("R1 e", e_o, 0); ck("R1 as", as_o, 0); ck("R1 oe", ad_oe_o, 0);
    ck("R1 rw", rw_o, 1); ck("R1 done", done_o, 0); ck("R1 accept", accept_o, 0);
    arst_n = 1'b1;
  endtask

  task automatic t_idle();
    logic [7:0] keep;
    sync_p0();
    keep = rdata_o;
    ad_i = 8'h5A;
    for (int p = 1; p < 8; p++) begin
      @(negedge clk);
      ck("R2 idle e", e_o, (p >= 4));
      ck("R3 idle as", as_o, (p == 1 || p == 2));
      ck("R10 idle oe", ad_oe_o, 0);
      ck("R10 idle rw", rw_o, 1);
    end
    @(negedge clk);
    ck("R10 idle no done", done_o, 0);
    ck("R10 idle rdata kept", rdata_o, keep);
  endtask

  task automatic t_late_req();
    sync_p0();
    @(negedge clk);
    req_i = 1'b1; rw_i = 1'b0; addr_i = 16'hBEEF; wdata_i = 8'h11;
    for (int p = 2; p < 8; p++) begin
      @(negedge clk);
      ck("R4 late no accept", accept_o, 0);
      ck("R4 late no drive", ad_oe_o, 0);
      ck("R4 late rw", rw_o, 1);
      if (p == 7) req_i = 1'b0;
    end
    @(negedge clk);
    ck("R4 late no done", done_o, 0);
  endtask

  task automatic t_chain();
    sync_p0();
    run_cycle(1'b0, 16'h12A5, 8'h3C);
    run_cycle(1'b1, 16'h8F01, 8'hC7);
    run_cycle(1'b1, 16'h0000, 8'hFF);
    run_cycle(1'b0, 16'hFFFF, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    sync_p0();
    run_cycle(1'b0, 16'hA55A, 8'h96);
    t_idle();
    sync_p0();
    run_cycle(1'b1, 16'h4321, 8'h7E);
    t_idle();
    t_late_req();
    t_chain();
    t_idle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule